// File: doc/BRIEF.md
# Row-Buffered DRAM Controller with SRAM-Style Request Port

This block lets logic use a wide DRAM core as if it were a pipelined SRAM. A requester presents a word address, a read/write flag and a 128-bit write word; it never issues row or column commands. Behind the port, a small set of row buffers holds whole open rows and behaves as a direct-mapped cache. Requests that find their row open are taken one per cycle, and read data comes back a fixed number of cycles later. Every core penalty is turned into back-pressure on the request port for a defined number of cycles: row misses, a write that follows a read straight away, and refresh halts from the host.

The request side is valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Once `req_valid` is raised, the address, flag and data must stay unchanged until the request is taken. `req_ready` is computed from the request being presented, so a request that would miss or needs a turnaround sees ready low at once. With `req_valid` low, ready only shows whether a penalty or halt is in progress. The response side carries no back-pressure: a read response is valid for one cycle, and the consumer must take it. The read pipeline keeps moving while the request port is stalled, so responses to requests already taken still arrive on time and in order.

The core array is behavioural and is not cleared at reset. A word that has never been written reads as undefined.

Top module: `rbc_top`

## Requirements
- R1: After reset no row buffer is valid, `rsp_valid` is low, and `req_ready` is high while no request is presented. The first access to any row is therefore a miss.
- R2: A request is taken exactly in a cycle where `req_valid` and `req_ready` are both high. In the running state with halt low, ready is high when no request is presented or when the presented request hits and needs no turnaround.
- R3: A read taken in cycle c drives `rsp_valid` high for one cycle in cycle c+6. In that cycle `rsp_rdata` holds the addressed word. Hits are taken back to back, one per cycle, and responses leave in the order the reads were taken.
- R4: Address bits [2:0] select the word within a row, bits [9:3] form the row number, and row bits [1:0] (address bits [4:3]) select one of four row buffers. A request whose row is not held in its buffer holds `req_ready` low for exactly 10 cycles. It is taken in the cycle after those 10.
- R5: A row buffer that has been written is copied back to the core array before it is refilled, so data written to a row survives that row's eviction and later refetch.
- R6: A write that is taken updates its row buffer at once. A read of the same word taken in any later cycle, including the very next one, returns the new data.
- R7: A write presented in the cycle right after a read was taken, with halt low, holds `req_ready` low for exactly 4 cycles.
- R8: While `halt` is high in the running state, `req_ready` is low. A miss or turnaround penalty that has already started runs to its end regardless of `halt`. A halt cycle between a read and a write removes the turnaround.
- R9: Penalties never overlap. A write that needs a turnaround and also misses sees 4 turnaround cycles and then 10 miss cycles, 14 in total, before it is taken.
- R10: Writes produce no response. `rsp_valid` is high only in cycles due to a taken read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Host refresh halt; blocks new requests while high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 128 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle per read) |
| rsp_rdata | output | 128 | Read data |

## Verification
On every cycle, the in-RTL assertions check the following. A finished fill leaves its buffer valid and tagged with the fetched row. A taken write marks its buffer dirty. A read followed at once by a write enters the turnaround. A turnaround and a fill never run into each other. A response stage is valid only if the stage before it was valid a cycle earlier. The exact stall lengths, the responses arriving at c+6 with correct data, data surviving a dirty eviction, and the interplay of halt with running penalties can only be shown by the bench's scenarios. For those, a behavioural model predicts ready and the response on every clock.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TURN = 2'd1,
    ST_FILL = 2'd2
  } rbc_state_e;
endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIDX_W   = 3,
  parameter int NUM_BUFS = 4,
  parameter int MISS_PEN = 10,
  parameter int TURN_PEN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     halt,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     req_ready,
  output logic                     accept,
  output logic [$clog2(NUM_BUFS)-1:0] cur_ent,
  output logic                     fill_go,
  output logic [$clog2(NUM_BUFS)-1:0] fill_ent,
  output logic [ADDR_W-WIDX_W-1:0] fill_row,
  output logic                     evict_go,
  output logic [ADDR_W-WIDX_W-1:0] evict_row
);
  localparam int ENT_W = $clog2(NUM_BUFS);
  localparam int ROW_W = ADDR_W - WIDX_W;
  localparam int MAXP  = (MISS_PEN > TURN_PEN) ? MISS_PEN : TURN_PEN;
  localparam int CNT_W = $clog2(MAXP + 1);

  rbc_state_e         st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ROW_W-1:0]   row_q [NUM_BUFS];
  logic [NUM_BUFS-1:0] vld_q, dirty_q;
  logic               rd_last_q;
  logic [ROW_W-1:0]   fill_row_q;
  logic [ENT_W-1:0]   fill_ent_q;

  logic [ROW_W-1:0]   row;
  logic               hit, turn_need, run_ok;

  always_comb begin
    row       = req_addr[ADDR_W-1:WIDX_W];
    cur_ent   = row[ENT_W-1:0];
    hit       = vld_q[cur_ent] && (row_q[cur_ent] == row);
    turn_need = req_valid && req_write && rd_last_q;
    run_ok    = (st_q == ST_RUN) && !halt;
    req_ready = run_ok && !(turn_need || (req_valid && !hit));
    accept    = req_valid && req_ready;
    fill_go   = (st_q == ST_FILL) && (cnt_q == '0);
    fill_ent  = fill_ent_q;
    fill_row  = fill_row_q;
    evict_go  = fill_go && vld_q[fill_ent_q] && dirty_q[fill_ent_q];
    evict_row = row_q[fill_ent_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      cnt_q      <= '0;
      vld_q      <= '0;
      dirty_q    <= '0;
      rd_last_q  <= 1'b0;
      fill_row_q <= '0;
      fill_ent_q <= '0;
      for (int i = 0; i < NUM_BUFS; i++) row_q[i] <= '0;
    end else begin
      rd_last_q <= accept && !req_write;
      if (accept && req_write) dirty_q[cur_ent] <= 1'b1;
      case (st_q)
        ST_RUN: begin
          if (run_ok && req_valid) begin
            if (turn_need) begin
              st_q  <= ST_TURN;
              cnt_q <= CNT_W'(TURN_PEN - 2);
            end else if (!hit) begin
              st_q       <= ST_FILL;
              cnt_q      <= CNT_W'(MISS_PEN - 2);
              fill_row_q <= row;
              fill_ent_q <= cur_ent;
            end
          end
        end
        ST_TURN: begin
          if (cnt_q == '0) st_q <= ST_RUN;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_FILL: begin
          if (cnt_q == '0) begin
            st_q                <= ST_RUN;
            vld_q[fill_ent_q]   <= 1'b1;
            dirty_q[fill_ent_q] <= 1'b0;
            row_q[fill_ent_q]   <= fill_row_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // R4: a completed fill leaves the buffer valid and tagged with the fetched row
  a_r4_fill_installs: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> (vld_q[$past(fill_ent_q)] && row_q[$past(fill_ent_q)] == $past(fill_row_q)));

  // R6: a taken write marks its buffer dirty
  a_r6_write_marks_dirty: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> dirty_q[$past(cur_ent)]);

  // R7: read then write with halt low starts a turnaround
  a_r7_turn_entry: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !halt && req_valid && req_write && rd_last_q) |=> (st_q == ST_TURN));

  // R9: penalties are serialised through the running state
  a_r9_turn_no_fill: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TURN) |=> (st_q != ST_FILL));
  a_r9_fill_no_turn: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FILL) |=> (st_q != ST_TURN));
endmodule

// File: rtl/rbc_row_store.sv
module rbc_row_store #(
  parameter int DATA_W   = 128,
  parameter int ADDR_W   = 10,
  parameter int WIDX_W   = 3,
  parameter int NUM_BUFS = 4
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_BUFS)-1:0]  acc_ent,
  input  logic [WIDX_W-1:0]            acc_word,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic                         fill_go,
  input  logic [$clog2(NUM_BUFS)-1:0]  fill_ent,
  input  logic [ADDR_W-WIDX_W-1:0]     fill_row,
  input  logic                         evict_go,
  input  logic [ADDR_W-WIDX_W-1:0]     evict_row
);
  localparam int WORDS    = 1 << WIDX_W;
  localparam int ROW_BITS = DATA_W * WORDS;
  localparam int NROWS    = 1 << (ADDR_W - WIDX_W);

  logic [ROW_BITS-1:0] core_q [NROWS];
  logic [ROW_BITS-1:0] buf_q  [NUM_BUFS];

  always_ff @(posedge clk) begin
    if (fill_go) begin
      if (evict_go) core_q[evict_row] <= buf_q[fill_ent];
      buf_q[fill_ent] <= core_q[fill_row];
    end
    if (wr_en) buf_q[acc_ent][int'(acc_word) * DATA_W +: DATA_W] <= wr_data;
  end

  assign rd_data = buf_q[acc_ent][int'(acc_word) * DATA_W +: DATA_W];
endmodule

// File: rtl/rbc_rd_pipe.sv
module rbc_rd_pipe #(
  parameter int DATA_W = 128,
  parameter int LAT    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];

  genvar g;
  generate
    for (g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) vld_q[0] <= 1'b0;
          else     vld_q[0] <= in_vld;
          dat_q[0] <= in_data;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= vld_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
        // R3: a stage is valid only if its predecessor was valid one cycle earlier
        a_r3_chain: assert property (@(posedge clk) disable iff (rst)
          vld_q[g] |-> $past(vld_q[g-1]));
      end
    end
  endgenerate

  assign out_vld  = vld_q[LAT-1];
  assign out_data = dat_q[LAT-1];
endmodule

// File: rtl/rbc_top.sv
module rbc_top #(
  parameter int DATA_W   = 128,
  parameter int ADDR_W   = 10,
  parameter int WIDX_W   = 3,
  parameter int NUM_BUFS = 4,
  parameter int HIT_LAT  = 6,
  parameter int MISS_PEN = 10,
  parameter int TURN_PEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int ENT_W = $clog2(NUM_BUFS);
  localparam int ROW_W = ADDR_W - WIDX_W;

  logic              accept, fill_go, evict_go;
  logic [ENT_W-1:0]  cur_ent, fill_ent;
  logic [ROW_W-1:0]  fill_row, evict_row;
  logic [DATA_W-1:0] buf_rd;

  rbc_ctrl #(
    .ADDR_W(ADDR_W), .WIDX_W(WIDX_W), .NUM_BUFS(NUM_BUFS),
    .MISS_PEN(MISS_PEN), .TURN_PEN(TURN_PEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .halt(halt),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .accept(accept), .cur_ent(cur_ent),
    .fill_go(fill_go), .fill_ent(fill_ent), .fill_row(fill_row),
    .evict_go(evict_go), .evict_row(evict_row)
  );

  rbc_row_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIDX_W(WIDX_W), .NUM_BUFS(NUM_BUFS)
  ) u_store (
    .clk(clk), .wr_en(accept && req_write), .acc_ent(cur_ent),
    .acc_word(req_addr[WIDX_W-1:0]), .wr_data(req_wdata), .rd_data(buf_rd),
    .fill_go(fill_go), .fill_ent(fill_ent), .fill_row(fill_row),
    .evict_go(evict_go), .evict_row(evict_row)
  );

  rbc_rd_pipe #(.DATA_W(DATA_W), .LAT(HIT_LAT)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(accept && !req_write), .in_data(buf_rd),
    .out_vld(rsp_valid), .out_data(rsp_rdata)
  );

  // R10: a response never appears in the cycle right after reset
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rsp_valid);
endmodule

// File: tb/rbc_top_bench.sv
module rbc_top_bench;
  localparam int NB = 4, MISS = 10, TURN = 4, LAT = 6, WD = 20000;

  logic clk = 1'b0, rst = 1'b1, halt = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [127:0] rsp_rdata;

  always #10 clk = ~clk;

  rbc_top u_rbc_top (
    .clk(clk), .rst(rst), .halt(halt), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int errors = 0, checks = 0, cyc = 0;
  string tag = "R3";

  // behavioural model state
  int busy = 0; bit busy_miss = 0; int inst_row = 0; bit last_rd = 0;
  int mrow [NB]; bit mvld [NB];
  logic [127:0] mem [int];
  int due_q [$]; logic [127:0] dat_q [$];
  bit n_acc = 0, n_wr = 0; int n_addr = 0, n_start = 0, n_row = 0, n_cyc = 0;
  logic [127:0] n_data = '0;

  function automatic logic [127:0] pat(int a, int k);
    return {4{32'(a * 7 + k * 131 + 5)}};
  endfunction

  task automatic chk(bit ok, string r, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle=%0d actual=%h expected=%h", r, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    int ent, row; bit miss, m_ready, war; string why; bit exp_v;
    row = int'(req_addr) >> 3; ent = row % NB;
    miss = !(mvld[ent] && mrow[ent] == row);
    war = req_valid && req_write && last_rd;
    n_start = 0;
    if (busy > 0) begin m_ready = 0; why = busy_miss ? "R4" : "R7"; end
    else if (halt) begin m_ready = 0; why = "R8"; end
    else if (war) begin m_ready = 0; why = miss ? "R9" : "R7"; n_start = 1; end
    else if (req_valid && miss) begin m_ready = 0; why = "R4"; n_start = 2; end
    else begin m_ready = 1; why = "R2"; end
    chk(req_ready === m_ready, why, "ready", 128'(req_ready), 128'(m_ready));
    exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
    chk(rsp_valid === exp_v, exp_v ? "R3" : "R10", "rsp_valid", 128'(rsp_valid), 128'(exp_v));
    if (exp_v) begin
      chk(rsp_rdata === dat_q[0], tag, "rsp_rdata", rsp_rdata, dat_q[0]);
      void'(due_q.pop_front()); void'(dat_q.pop_front());
    end
    n_acc = req_valid && m_ready; n_wr = req_write; n_addr = int'(req_addr);
    n_data = req_wdata; n_row = row; n_cyc = cyc;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (busy > 0) begin
        busy--;
        if (busy == 0 && busy_miss) begin mvld[inst_row % NB] = 1; mrow[inst_row % NB] = inst_row; end
      end else if (n_start == 1) begin busy = TURN - 1; busy_miss = 0; end
      else if (n_start == 2) begin busy = MISS - 1; busy_miss = 1; inst_row = n_row; end
      last_rd = n_acc && !n_wr;
      if (n_acc) begin
        if (n_wr) mem[n_addr] = n_data;
        else begin due_q.push_back(n_cyc + LAT); dat_q.push_back(mem[n_addr]); end
      end
      n_acc = 0; n_start = 0;
    end
    if (cyc > WD) begin
      errors++; checks++;
      $display("FAIL R2 watchdog cycles=%0d expected<%0d", cyc, WD);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(bit w, int a, logic [127:0] d);
    req_valid = 1; req_write = w; req_addr = 10'(a); req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin mvld[i] = 0; mrow[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "reset state",
        {126'd0, rsp_valid, req_ready}, 128'd1);
    @(posedge clk); #1;

    tag = "R6";   // first write misses (R1/R4), rest hit back to back
    for (int i = 0; i < 8; i++) send(1, i, pat(i, 0));
    tag = "R3";
    for (int i = 0; i < 8; i++) send(0, i, '0);
    tag = "R7";   // read then write directly
    send(0, 2, '0); send(1, 3, pat(3, 1)); send(0, 3, '0);
    idle(8);
    tag = "R5";   // conflict on buffer 0 with dirty row
    send(1, 32, pat(32, 0)); send(0, 0, '0); send(0, 32, '0); send(0, 5, '0);
    idle(8);
    tag = "R8";
    halt = 1;
    fork
      send(0, 1, '0);
      begin idle(5); halt = 0; end
    join
    fork
      send(0, 40, '0);
      begin idle(3); halt = 1; idle(12); halt = 0; end
    join
    send(1, 40, pat(40, 2));
    idle(8);
    tag = "R9";   // turnaround then miss
    send(0, 0, '0); send(1, 64, pat(64, 0)); send(0, 64, '0);
    idle(8);
    tag = "R10";
    for (int i = 8; i < 12; i++) send(1, i, pat(i, 3));
    idle(10);
    tag = "R6";
    begin
      int ap; ap = 0;
      for (int i = 0; i < 30; i++) begin
        int a; a = (i % 8) + 32 * ((i / 4) % 3);
        if (i % 2 == 0) begin send(1, a, pat(a, i)); ap = a; end
        else send(0, ap, '0);
      end
    end
    idle(12);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule